// File: doc/BRIEF.md
# Processor Cache Coherence Response Handler

This block is the coherence agent on the processor side of a small direct-mapped cache. Each cycle it takes at most one message from an ordered inbound channel and acts on it. Fills install a line. Invalidates drop a line. Forwarded reads from the directory make the block send the line's data to the requesting agent. Commit responses retire outstanding requests.

Commits are counted apart from data. A read's data can reach the core while its commit is still in flight. A memory barrier is released only when no commit remains outstanding.

A combinational lookup port lets the core see the line that an address maps to: whether it is present, whether it is dirty, and what data it holds.

Top module: `coh_resp_agent`

## Requirements
- R1: A Fill (kind 1) with subtype 1 (Mod) sets the indexed line (index = address bits [IDX_W-1:0]) to ExclusiveDirty. The line's tag comes from the upper address bits and its data from the message payload. After the edge, the lookup reports hit=1, dirty=1 and that data.
- R2: A Fill with subtype 0 or 3 installs tag and data the same way and leaves the line Clean (lookup hit=1, dirty=0).
- R3: A Fill with subtype 2 (Fetch) changes no line state, tag or data.
- R4: An Invalidate (kind 2) whose tag matches a valid indexed line makes the line Invalid. An Invalidate whose tag does not match leaves the cache unchanged.
- R5: A forwarded read (kind 4) that hits makes the block present one Data beat in the cycle after the message. The beat carries destination = message source, address = message address, and the line's data. The line stays valid, and ExclusiveDirty becomes Clean. A forwarded read that misses sends nothing.
- R6: A forwarded exclusive read (kind 5) that hits sends the same Data beat and makes the line Invalid. A miss sends nothing.
- R7: Each cycle with issue_req high adds one to the outstanding-commit count. Each Commit (kind 3) subtracts one. When both occur in the same cycle the count is unchanged. A Commit at zero is ignored, and an issue at the maximum (2^CNT_W-1) is ignored.
- R8: bar_done is high exactly while bar_req is high and the outstanding count is zero. Returned data has no effect on it.
- R9: Messages are applied one per cycle in arrival order. An Invalidate that arrives before the last Commit has already taken effect in the lookup by the time bar_done rises.
- R10: After reset every line is Invalid, the count is zero and no Data beat is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Inbound message present this cycle |
| msg_kind | input | 3 | 1 Fill, 2 Invalidate, 3 Commit, 4 forwarded read, 5 forwarded exclusive read |
| msg_sub | input | 2 | Fill subtype: 0 plain, 1 Mod, 2 Fetch |
| msg_addr | input | ADDR_W | Line address |
| msg_src | input | ID_W | Requesting agent of a forwarded read |
| msg_data | input | DATA_W | Fill payload |
| issue_req | input | 1 | Core issued a request that awaits a commit |
| bar_req | input | 1 | Memory barrier waiting |
| bar_done | output | 1 | Barrier may pass |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Lookup line valid with matching tag |
| lk_dirty | output | 1 | Lookup line is ExclusiveDirty |
| lk_data | output | DATA_W | Lookup line data (zero on miss) |
| dout_valid | output | 1 | Outbound Data beat valid |
| dout_dest | output | ID_W | Destination agent of the Data beat |
| dout_addr | output | ADDR_W | Address of the Data beat |
| dout_data | output | DATA_W | Line data sent |

## Verification
The hardest situation to reach is the ordering case. An Invalidate has to arrive ahead of the final outstanding Commit while a barrier is already waiting. The line it removes then has to be seen as gone in the same cycle the barrier is released.

The stimulus reaches it by directed steps. It issues a request with the barrier held high, installs a line, sends the Invalidate and then the Commit. After the Commit it probes that line's address.

Saturation of the counter at both ends is reached by long runs of issues and commits. A random phase then mixes all message kinds over a small pool of colliding addresses.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV   = 2'd0,
    LN_CLEAN = 2'd1,
    LN_EXD   = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    MK_NONE     = 3'd0,
    MK_FILL     = 3'd1,
    MK_INVAL    = 3'd2,
    MK_COMMIT   = 3'd3,
    MK_FWD_RD   = 3'd4,
    MK_FWD_RDEX = 3'd5
  } msg_kind_e;

  localparam logic [1:0] FS_PLAIN = 2'd0;
  localparam logic [1:0] FS_MOD   = 2'd1;
  localparam logic [1:0] FS_FETCH = 2'd2;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_state,
  input  logic              wr_fill,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_arr  [LINES];
  logic [TAG_W-1:0]  tag_arr [LINES];
  logic [DATA_W-1:0] dat_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              sel;
    line_st_e          st_d, st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      st_d = st_q;
      if (sel) st_d = wr_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LN_INV;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (sel && wr_fill) begin
        tag_q <= wr_tag;
        dat_q <= wr_data;
      end
    end

    assign st_arr[g]  = st_q;
    assign tag_arr[g] = tag_q;
    assign dat_arr[g] = dat_q;
  end

  assign a_state = st_arr[a_idx];
  assign a_tag   = tag_arr[a_idx];
  assign a_data  = dat_arr[a_idx];
  assign b_state = st_arr[b_idx];
  assign b_tag   = tag_arr[b_idx];
  assign b_data  = dat_arr[b_idx];

  // R1 / R4: a requested state write is what the line holds afterwards
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> st_arr[$past(wr_idx)] == $past(wr_state));
endmodule

// File: rtl/coh_commit_ctr.sv
module coh_commit_ctr #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic bar_req,
  output logic bar_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (dec && !inc) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bar_done = bar_req && (cnt_q == '0);

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)
             || (cnt_q == $past(cnt_q) - 1'b1));

  assert_cnt_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec && !inc) |=> cnt_q == '0);

  assert_cnt_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !dec) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/coh_fwd_resp.sv
module coh_fwd_resp #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  logic [ID_W-1:0]   dest,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_dest,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= send;
  end

  always_ff @(posedge clk) begin
    if (send) begin
      out_dest <= dest;
      out_addr <= addr;
      out_data <= data;
    end
  end
endmodule

// File: rtl/coh_resp_agent.sv
module coh_resp_agent
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [2:0]        msg_kind,
  input  logic [1:0]        msg_sub,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [ID_W-1:0]   msg_src,
  input  logic [DATA_W-1:0] msg_data,
  input  logic              issue_req,
  input  logic              bar_req,
  output logic              bar_done,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_dirty,
  output logic [DATA_W-1:0] lk_data,
  output logic              dout_valid,
  output logic [ID_W-1:0]   dout_dest,
  output logic [ADDR_W-1:0] dout_addr,
  output logic [DATA_W-1:0] dout_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  msg_kind_e         kind;
  logic [IDX_W-1:0]  m_idx, l_idx;
  logic [TAG_W-1:0]  m_tag, l_tag;
  line_st_e          a_state, b_state, wr_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  logic              m_hit, wr_en, wr_fill, send, commit;

  assign kind  = msg_kind_e'(msg_kind);
  assign m_idx = msg_addr[IDX_W-1:0];
  assign m_tag = msg_addr[ADDR_W-1:IDX_W];
  assign l_idx = lk_addr[IDX_W-1:0];
  assign l_tag = lk_addr[ADDR_W-1:IDX_W];
  assign m_hit = (a_state != LN_INV) && (a_tag == m_tag);

  always_comb begin
    wr_en    = 1'b0;
    wr_fill  = 1'b0;
    wr_state = a_state;
    send     = 1'b0;
    commit   = 1'b0;
    if (msg_valid) begin
      unique case (kind)
        MK_FILL: begin
          if (msg_sub != FS_FETCH) begin
            wr_en    = 1'b1;
            wr_fill  = 1'b1;
            wr_state = (msg_sub == FS_MOD) ? LN_EXD : LN_CLEAN;
          end
        end
        MK_INVAL: begin
          if (m_hit) begin
            wr_en    = 1'b1;
            wr_state = LN_INV;
          end
        end
        MK_COMMIT: commit = 1'b1;
        MK_FWD_RD: begin
          if (m_hit) begin
            send = 1'b1;
            if (a_state == LN_EXD) begin
              wr_en    = 1'b1;
              wr_state = LN_CLEAN;
            end
          end
        end
        MK_FWD_RDEX: begin
          if (m_hit) begin
            send     = 1'b1;
            wr_en    = 1'b1;
            wr_state = LN_INV;
          end
        end
        default: ;
      endcase
    end
  end

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(m_idx), .wr_state(wr_state), .wr_fill(wr_fill),
    .wr_tag(m_tag), .wr_data(msg_data),
    .a_idx(m_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(l_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data)
  );

  coh_commit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(issue_req), .dec(commit),
    .bar_req(bar_req), .bar_done(bar_done)
  );

  coh_fwd_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .send(send), .dest(msg_src), .addr(msg_addr),
    .data(a_data), .out_valid(dout_valid), .out_dest(dout_dest),
    .out_addr(dout_addr), .out_data(dout_data)
  );

  assign lk_hit   = (b_state != LN_INV) && (b_tag == l_tag);
  assign lk_dirty = lk_hit && (b_state == LN_EXD);
  assign lk_data  = lk_hit ? b_data : '0;

  // R5 / R6: a Data beat only follows a forwarded request
  assert_resp_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(msg_valid && (msg_kind == MK_FWD_RD || msg_kind == MK_FWD_RDEX)));

  assert_fetch_no_install_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MK_FILL && msg_sub == FS_FETCH) |-> !wr_en);

  assert_exclusive_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MK_FWD_RDEX && m_hit) |=> dout_valid);
endmodule

// File: tb/coh_resp_agent_test.sv
module coh_resp_agent_test;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int CNT_W  = 4;
  localparam int LINES  = 1 << IDX_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0;
  logic [2:0] msg_kind = '0;
  logic [1:0] msg_sub = '0;
  logic [ADDR_W-1:0] msg_addr = '0;
  logic [ID_W-1:0] msg_src = '0;
  logic [DATA_W-1:0] msg_data = '0;
  logic issue_req = 1'b0;
  logic bar_req = 1'b0;
  logic bar_done;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic lk_hit, lk_dirty;
  logic [DATA_W-1:0] lk_data;
  logic dout_valid;
  logic [ID_W-1:0] dout_dest;
  logic [ADDR_W-1:0] dout_addr;
  logic [DATA_W-1:0] dout_data;

  always #2 clk = ~clk;

  coh_resp_agent #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
                   .ID_W(ID_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_sub(msg_sub), .msg_addr(msg_addr), .msg_src(msg_src),
    .msg_data(msg_data), .issue_req(issue_req), .bar_req(bar_req),
    .bar_done(bar_done), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_dirty(lk_dirty), .lk_data(lk_data), .dout_valid(dout_valid),
    .dout_dest(dout_dest), .dout_addr(dout_addr), .dout_data(dout_data)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model: 0 invalid, 1 clean, 2 dirty
  int m_st [LINES];
  int m_tag [LINES];
  logic [DATA_W-1:0] m_dat [LINES];
  int m_cnt = 0;
  bit e_dv = 1'b0;
  int e_dest = 0, e_addr = 0;
  logic [DATA_W-1:0] e_data = '0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req, int probe);
    int pi = probe % LINES;
    int pt = probe / LINES;
    bit eh = (m_st[pi] != 0) && (m_tag[pi] == pt);
    chk(req, "lk_hit", 64'(lk_hit), 64'(eh));
    chk(req, "lk_dirty", 64'(lk_dirty), 64'(eh && m_st[pi] == 2));
    chk(req, "lk_data", 64'(lk_data), eh ? 64'(m_dat[pi]) : 64'd0);
    chk(req, "dout_valid", 64'(dout_valid), 64'(e_dv));
    if (e_dv) begin
      chk(req, "dout_dest", 64'(dout_dest), 64'(e_dest));
      chk(req, "dout_addr", 64'(dout_addr), 64'(e_addr));
      chk(req, "dout_data", 64'(dout_data), 64'(e_data));
    end
    chk("R8", "bar_done", 64'(bar_done), 64'(bar_req && m_cnt == 0));
  endtask

  task automatic step(int kind, int sub, int addr, int src, logic [DATA_W-1:0] d,
                      bit iss, bit breq, int probe, string tag);
    int idx, tg;
    bit hit;
    string req;
    msg_valid = (kind != 0);
    msg_kind  = 3'(kind);
    msg_sub   = 2'(sub);
    msg_addr  = ADDR_W'(addr);
    msg_src   = ID_W'(src);
    msg_data  = d;
    issue_req = iss;
    bar_req   = breq;
    lk_addr   = ADDR_W'(probe);
    @(posedge clk);
    idx = addr % LINES;
    tg  = addr / LINES;
    hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    e_dv = 1'b0;
    req = "R8";
    case (kind)
      1: begin
        req = (sub == 1) ? "R1" : (sub == 2) ? "R3" : "R2";
        if (sub != 2) begin
          m_st[idx] = (sub == 1) ? 2 : 1;
          m_tag[idx] = tg;
          m_dat[idx] = d;
        end
      end
      2: begin req = "R4"; if (hit) m_st[idx] = 0; end
      4: begin
        req = "R5";
        if (hit) begin
          e_dv = 1; e_dest = src; e_addr = addr; e_data = m_dat[idx];
          if (m_st[idx] == 2) m_st[idx] = 1;
        end
      end
      5: begin
        req = "R6";
        if (hit) begin
          e_dv = 1; e_dest = src; e_addr = addr; e_data = m_dat[idx];
          m_st[idx] = 0;
        end
      end
      default: ;
    endcase
    if (kind == 3 || iss) req = "R7";
    if (iss && kind != 3) begin
      if (m_cnt != CMAX) m_cnt++;
    end else if (kind == 3 && !iss) begin
      if (m_cnt != 0) m_cnt--;
    end
    if (tag != "") req = tag;
    @(negedge clk);
    compare(req, probe);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bar_req = 1'b1;
    @(negedge clk);
    // R10: reset state
    for (int i = 0; i < LINES; i++) begin
      lk_addr = ADDR_W'(i);
      #0;
      chk("R10", "lk_hit after reset", 64'(lk_hit), 64'd0);
    end
    chk("R10", "dout_valid after reset", 64'(dout_valid), 64'd0);
    chk("R10", "bar_done after reset", 64'(bar_done), 64'd1);

    step(1, 1, 'h105, 0, 32'hA5A5_0001, 0, 0, 'h105, "R1");
    step(1, 0, 'h023, 0, 32'h0000_0C23, 0, 0, 'h023, "R2");
    step(1, 3, 'h044, 0, 32'h0000_0D44, 0, 0, 'h044, "R2");
    step(1, 2, 'h203, 0, 32'hDEAD_BEEF, 0, 0, 'h023, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 'h203, "R3");
    step(2, 0, 'h305, 0, 0, 0, 0, 'h105, "R4");
    step(4, 0, 'h105, 7, 0, 0, 0, 'h105, "R5");
    step(4, 0, 'h777, 3, 0, 0, 0, 'h105, "R5");
    step(5, 0, 'h023, 2, 0, 0, 0, 'h023, "R6");
    step(5, 0, 'h023, 2, 0, 0, 0, 'h023, "R6");
    step(2, 0, 'h105, 0, 0, 0, 0, 'h105, "R4");

    // R7 / R8: counting with barrier waiting
    step(0, 0, 0, 0, 0, 1, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R7");
    step(4, 0, 'h044, 5, 0, 0, 1, 'h044, "R8");
    step(3, 0, 0, 0, 0, 1, 1, 0, "R7");
    step(3, 0, 0, 0, 0, 0, 1, 0, "R7");
    // R9: inval ahead of last commit
    step(1, 1, 'h1F6, 0, 32'h1234_5678, 0, 1, 'h1F6, "R9");
    step(2, 0, 'h1F6, 0, 0, 0, 1, 'h1F6, "R9");
    step(3, 0, 0, 0, 0, 0, 1, 'h1F6, "R9");
    step(3, 0, 0, 0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 1, 1, 0, "R7");
    for (int i = 0; i < CMAX; i++) step(3, 0, 0, 0, 0, 0, 1, 0, "R7");

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 5);
      int a = ($urandom_range(0, 3) << IDX_W) | $urandom_range(0, 3);
      step(k, $urandom_range(0, 3), a, $urandom_range(0, 15), $urandom,
           $urandom_range(0, 3) == 0, $urandom_range(0, 1),
           (($urandom_range(0, 3) << IDX_W) | $urandom_range(0, 3)), "");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule